// File: doc/BRIEF.md
# GCM Request Segment Formatter

This block assembles the request stream for an authenticated-encryption engine working in its link-security profile. For each packet a header is accepted with the channel number, a 96-bit initialization vector, the AAD length in bytes and the text length in bytes. The packet body follows as 128-bit words. The body is one contiguous little-endian byte stream: the AAD bytes, and directly after them the text bytes. Byte i of a word sits at bits [8i+7:8i].

Output beats are 512 bits wide and hold four 128-bit segments. Each segment carries a 2-bit type tag: 00 idle, 01 IV, 10 AAD, 11 text. Segment k is bits [128k+127:128k], and its tag is out_tag_o[2k+1:2k].

- The first beat of a packet carries the initial counter block in segment 0. The body words fill every following segment in arrival order.
- Each beat is driven with the profile select value 2.
- Each beat is marked with start and end of packet where they apply.
- The final beat reports how many bytes of its last data segment are valid.

A packet always begins on a fresh beat, so a beat never holds two starts, two ends or two IVs. Requests with a zero AAD or text length are refused. The output is held stable under backpressure.

Top module: `gcm_seg_fmt`

## Requirements
- R1: Every output beat drives out_pattern_o to 3'd2.
- R2: The first beat of a packet has out_sop_o=1 and carries {32'd2, iv} in segment 0 with tag 01. Bits [103:96] hold the counter's low byte 8'h02. No other segment of any beat is tagged 01.
- R3: Body word k, counted from 0, is placed in overall slot k+1, where slot = beat*4 + segment. It is forwarded unchanged.
- R4: A data segment is tagged 10 (AAD) when its first byte offset 16k is below the AAD length, and 11 (text) otherwise. Segments after the last data segment are tagged 00 and carry all-zero data.
- R5: Text continues in the segment where the AAD ends, with no padding. A packet uses ceil((aad+txt)/16) data segments and ceil((that+1)/4) beats.
- R6: Each packet gives exactly one beat with out_sop_o and one beat with out_eop_o. Every beat before the last has a non-idle segment 3, and the next packet starts on a new beat.
- R7: out_last_bytes_o equals ((aad+txt-1) mod 16)+1 on the end-of-packet beat and 0 on other beats.
- R8: While out_valid_o=1 and out_ready_i=0, the beat and all its sideband fields stay unchanged in the next cycle.
- R9: A request with zero AAD length or zero text length is accepted. It raises err_o for one cycle and produces no output beat.
- R10: After reset, out_valid_o=0, dat_ready_o=0, err_o=0 and req_ready_o=1.
- R11: out_chan_o carries the request's channel on every beat of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Packet header valid |
| req_ready_o | output | 1 | Header accepted when high with valid |
| req_chan_i | input | CHAN_W | Channel number |
| req_iv_i | input | 96 | Initialization vector |
| req_aad_len_i | input | AAD_LEN_W | AAD length in bytes |
| req_txt_len_i | input | TXT_LEN_W | Text length in bytes |
| dat_valid_i | input | 1 | Body word valid |
| dat_ready_o | output | 1 | Body word accepted when high with valid |
| dat_i | input | 128 | Body word, AAD then text bytes |
| out_valid_o | output | 1 | Beat valid |
| out_ready_i | input | 1 | Engine accepts beat |
| out_data_o | output | SEGS*128 | Beat data |
| out_tag_o | output | 2*SEGS | Per-segment type tags |
| out_sop_o | output | 1 | First beat of packet |
| out_eop_o | output | 1 | Last beat of packet |
| out_pattern_o | output | 3 | Profile select |
| out_chan_o | output | CHAN_W | Channel of the beat |
| out_last_bytes_o | output | 5 | Valid bytes in final data segment |
| err_o | output | 1 | Zero-length request refused |

## Verification
A corrupted slot pointer misplaces a body word or its tag, and this shows in the very beat being formed. A wrong segment counter or wrong latched lengths show at that packet's end: out_eop_o comes a beat early or late, out_last_bytes_o is wrong, or an AAD/text tag boundary is misplaced. A beat register that is not held shows as a changed output in the cycle after a refused beat. Packets of one word, packets that exactly fill a beat, packets spanning many beats, and refused requests are run under irregular backpressure.

// File: rtl/gcm_fmt_pkg.sv
`timescale 1ns/1ps
package gcm_fmt_pkg;
  localparam int unsigned SEG_W     = 128;
  localparam int unsigned IV_W      = 96;
  localparam int unsigned CTR_W     = 32;
  localparam logic [2:0]  PATTERN_SEL = 3'd2;
  localparam logic [CTR_W-1:0] CTR_START = 32'd2;

  typedef enum logic [1:0] {
    TAG_IDLE = 2'b00,
    TAG_IV   = 2'b01,
    TAG_AAD  = 2'b10,
    TAG_TXT  = 2'b11
  } seg_tag_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_SEND
  } fmt_state_e;
endpackage

// File: rtl/gcm_fmt_ctrblk.sv
`timescale 1ns/1ps
module gcm_fmt_ctrblk
  import gcm_fmt_pkg::*;
(
  input  logic [IV_W-1:0]  iv_i,
  output logic [SEG_W-1:0] blk_o
);
  // counter sits above the IV, low byte first at bit 96
  assign blk_o = {CTR_START, iv_i};
endmodule

// File: rtl/gcm_fmt_geom.sv
`timescale 1ns/1ps
module gcm_fmt_geom
  import gcm_fmt_pkg::*;
#(
  parameter int unsigned AAD_LEN_W = 32,
  parameter int unsigned TXT_LEN_W = 16
) (
  input  logic [AAD_LEN_W-1:0] aad_len_i,
  input  logic [TXT_LEN_W-1:0] txt_len_i,
  input  logic [((AAD_LEN_W > TXT_LEN_W) ? AAD_LEN_W : TXT_LEN_W)-2:0] seg_idx_i,
  output logic [((AAD_LEN_W > TXT_LEN_W) ? AAD_LEN_W : TXT_LEN_W)-2:0] n_segs_o,
  output logic [4:0]           last_bytes_o,
  output seg_tag_e             tag_o
);
  localparam int unsigned TOT_W  = ((AAD_LEN_W > TXT_LEN_W) ? AAD_LEN_W : TXT_LEN_W) + 1;
  localparam int unsigned NSEG_W = TOT_W - 3;

  logic [TOT_W:0] tot, tot_rnd, start, aad_ext;

  assign aad_ext = (TOT_W+1)'(aad_len_i);
  assign tot     = aad_ext + (TOT_W+1)'(txt_len_i);
  assign tot_rnd = tot + (TOT_W+1)'(15);
  assign start   = {seg_idx_i, 4'b0000};

  assign n_segs_o     = tot_rnd[TOT_W:4];
  assign last_bytes_o = (tot[3:0] == 4'd0) ? 5'd16 : {1'b0, tot[3:0]};
  assign tag_o        = (start < aad_ext) ? TAG_AAD : TAG_TXT;

  logic unused_nseg;
  assign unused_nseg = (NSEG_W == 0);
endmodule

// File: rtl/gcm_fmt_beat.sv
`timescale 1ns/1ps
module gcm_fmt_beat
  import gcm_fmt_pkg::*;
#(
  parameter int unsigned SEGS   = 4,
  parameter int unsigned SLOT_W = $clog2(SEGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [SEG_W-1:0]       iv_blk_i,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [SLOT_W-1:0]      slot_i,
  input  logic [SEG_W-1:0]       seg_i,
  input  seg_tag_e               tag_i,
  output logic [SEGS*SEG_W-1:0]  data_o,
  output logic [2*SEGS-1:0]      tag_o
);
  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    logic [SEG_W-1:0] seg_q;
    logic [1:0]       tag_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seg_q <= '0;
        tag_q <= TAG_IDLE;
      end else if (start_i) begin
        seg_q <= (g == 0) ? iv_blk_i : '0;
        tag_q <= (g == 0) ? TAG_IV : TAG_IDLE;
      end else if (clr_i) begin
        seg_q <= '0;
        tag_q <= TAG_IDLE;
      end else if (wr_i && slot_i == SLOT_W'(g)) begin
        seg_q <= seg_i;
        tag_q <= tag_i;
      end
    end

    assign data_o[g*SEG_W +: SEG_W] = seg_q;
    assign tag_o[2*g +: 2]          = tag_q;
  end
endmodule

// File: rtl/gcm_seg_fmt.sv
`timescale 1ns/1ps
module gcm_seg_fmt
  import gcm_fmt_pkg::*;
#(
  parameter int unsigned CHAN_W    = 10,
  parameter int unsigned AAD_LEN_W = 32,
  parameter int unsigned TXT_LEN_W = 16,
  parameter int unsigned SEGS      = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [CHAN_W-1:0]     req_chan_i,
  input  logic [IV_W-1:0]       req_iv_i,
  input  logic [AAD_LEN_W-1:0]  req_aad_len_i,
  input  logic [TXT_LEN_W-1:0]  req_txt_len_i,
  input  logic                  dat_valid_i,
  output logic                  dat_ready_o,
  input  logic [SEG_W-1:0]      dat_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [SEGS*SEG_W-1:0] out_data_o,
  output logic [2*SEGS-1:0]     out_tag_o,
  output logic                  out_sop_o,
  output logic                  out_eop_o,
  output logic [2:0]            out_pattern_o,
  output logic [CHAN_W-1:0]     out_chan_o,
  output logic [4:0]            out_last_bytes_o,
  output logic                  err_o
);
  localparam int unsigned SLOT_W = $clog2(SEGS);
  localparam int unsigned TOT_W  = ((AAD_LEN_W > TXT_LEN_W) ? AAD_LEN_W : TXT_LEN_W) + 1;
  localparam int unsigned NSEG_W = TOT_W - 3;

  fmt_state_e           state_q;
  logic [SLOT_W-1:0]    slot_q;
  logic [NSEG_W-1:0]    seg_idx_q, n_segs;
  logic [CHAN_W-1:0]    chan_q;
  logic [AAD_LEN_W-1:0] aad_q;
  logic [TXT_LEN_W-1:0] txt_q;
  logic                 sop_q, eop_q, err_q;
  logic [SEG_W-1:0]     iv_blk;
  logic [4:0]           last_bytes;
  seg_tag_e             seg_tag;

  logic req_zero, req_fire, start, dat_fire, out_fire, last_seg, slot_full;

  assign req_zero  = (req_aad_len_i == '0) || (req_txt_len_i == '0);
  assign req_fire  = (state_q == ST_IDLE) && req_valid_i;
  assign start     = req_fire && !req_zero;
  assign dat_fire  = (state_q == ST_FILL) && dat_valid_i;
  assign out_fire  = (state_q == ST_SEND) && out_ready_i;
  assign last_seg  = (seg_idx_q == n_segs - NSEG_W'(1));
  assign slot_full = (slot_q == SLOT_W'(SEGS-1));

  gcm_fmt_ctrblk u_ctrblk (
    .iv_i  (req_iv_i),
    .blk_o (iv_blk)
  );

  gcm_fmt_geom #(
    .AAD_LEN_W (AAD_LEN_W),
    .TXT_LEN_W (TXT_LEN_W)
  ) u_geom (
    .aad_len_i    (aad_q),
    .txt_len_i    (txt_q),
    .seg_idx_i    (seg_idx_q),
    .n_segs_o     (n_segs),
    .last_bytes_o (last_bytes),
    .tag_o        (seg_tag)
  );

  gcm_fmt_beat #(
    .SEGS   (SEGS),
    .SLOT_W (SLOT_W)
  ) u_beat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .iv_blk_i (iv_blk),
    .clr_i    (out_fire && !eop_q),
    .wr_i     (dat_fire),
    .slot_i   (slot_q),
    .seg_i    (dat_i),
    .tag_i    (seg_tag),
    .data_o   (out_data_o),
    .tag_o    (out_tag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      slot_q    <= '0;
      seg_idx_q <= '0;
      chan_q    <= '0;
      aad_q     <= '0;
      txt_q     <= '0;
      sop_q     <= 1'b0;
      eop_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= req_fire && req_zero;
      unique case (state_q)
        ST_IDLE: if (start) begin
          chan_q    <= req_chan_i;
          aad_q     <= req_aad_len_i;
          txt_q     <= req_txt_len_i;
          slot_q    <= SLOT_W'(1);  // slot 0 holds the counter block
          seg_idx_q <= '0;
          sop_q     <= 1'b1;
          eop_q     <= 1'b0;
          state_q   <= ST_FILL;
        end
        ST_FILL: if (dat_fire) begin
          seg_idx_q <= seg_idx_q + NSEG_W'(1);
          if (last_seg) begin
            eop_q   <= 1'b1;
            state_q <= ST_SEND;
          end else if (slot_full) begin
            state_q <= ST_SEND;
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
          end
        end
        ST_SEND: if (out_fire) begin
          if (eop_q) begin
            state_q <= ST_IDLE;
          end else begin
            slot_q  <= '0;
            sop_q   <= 1'b0;
            state_q <= ST_FILL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o      = (state_q == ST_IDLE);
  assign dat_ready_o      = (state_q == ST_FILL);
  assign out_valid_o      = (state_q == ST_SEND);
  assign out_sop_o        = sop_q;
  assign out_eop_o        = eop_q;
  assign out_pattern_o    = PATTERN_SEL;
  assign out_chan_o       = chan_q;
  assign out_last_bytes_o = eop_q ? last_bytes : 5'd0;
  assign err_o            = err_q;
endmodule

// File: rtl/gcm_fmt_chk.sv
`timescale 1ns/1ps
module gcm_fmt_chk
  import gcm_fmt_pkg::*;
#(
  parameter int unsigned SEGS   = 4,
  parameter int unsigned CHAN_W = 10
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  out_valid_o,
  input logic                  out_ready_i,
  input logic [SEGS*SEG_W-1:0] out_data_o,
  input logic [2*SEGS-1:0]     out_tag_o,
  input logic                  out_sop_o,
  input logic                  out_eop_o,
  input logic [CHAN_W-1:0]     out_chan_o,
  input logic [4:0]            out_last_bytes_o,
  input logic                  err_o
);
  AST_HOLD_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_tag_o)
      && $stable(out_sop_o) && $stable(out_eop_o) && $stable(out_chan_o))); // R8

  AST_SOP_IV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sop_o) |-> (out_tag_o[1:0] == TAG_IV)); // R2

  AST_LASTB_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_eop_o) |-> (out_last_bytes_o != 5'd0 && out_last_bytes_o <= 5'd16)); // R7

  AST_LASTB_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_eop_o) |-> (out_last_bytes_o == 5'd0)); // R7

  AST_FULL_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_eop_o) |-> (out_tag_o[2*SEGS-1 -: 2] != TAG_IDLE)); // R6

  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !out_valid_o); // R9

  for (genvar g = 0; g < SEGS; g++) begin : g_seg_chk
    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && out_tag_o[2*g +: 2] == TAG_IDLE) |-> (out_data_o[g*SEG_W +: SEG_W] == '0)); // R4
    if (g != 0) begin : g_no_iv
      AST_IV_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (out_tag_o[2*g +: 2] != TAG_IV)); // R2
    end
  end
endmodule

bind gcm_seg_fmt gcm_fmt_chk #(
  .SEGS   (SEGS),
  .CHAN_W (CHAN_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .out_valid_o      (out_valid_o),
  .out_ready_i      (out_ready_i),
  .out_data_o       (out_data_o),
  .out_tag_o        (out_tag_o),
  .out_sop_o        (out_sop_o),
  .out_eop_o        (out_eop_o),
  .out_chan_o       (out_chan_o),
  .out_last_bytes_o (out_last_bytes_o),
  .err_o            (err_o)
);

// File: tb/gcm_seg_fmt_tb_top.sv
`timescale 1ns/1ps
module gcm_seg_fmt_tb_top;
  localparam int CHAN_W = 10;
  localparam int AAD_W  = 32;
  localparam int TXT_W  = 16;
  localparam int SEGS   = 4;
  localparam int BEAT_W = SEGS*128;

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic [2*SEGS-1:0] tag;
    logic              sop;
    logic              eop;
    logic [4:0]        lastb;
    logic [CHAN_W-1:0] chan;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [CHAN_W-1:0] req_chan = '0;
  logic [95:0] req_iv = '0;
  logic [AAD_W-1:0] req_aad = '0;
  logic [TXT_W-1:0] req_txt = '0;
  logic dat_valid = 1'b0, dat_ready;
  logic [127:0] dat = '0;
  logic out_valid, out_ready = 1'b0;
  logic [BEAT_W-1:0] out_data;
  logic [2*SEGS-1:0] out_tag;
  logic out_sop, out_eop;
  logic [2:0] out_pattern;
  logic [CHAN_W-1:0] out_chan;
  logic [4:0] out_lastb;
  logic err;

  int checks = 0, fails = 0;
  bit done = 0;
  beat_t exp_q[$];

  always #5 clk = ~clk;

  gcm_seg_fmt #(.CHAN_W(CHAN_W), .AAD_LEN_W(AAD_W), .TXT_LEN_W(TXT_W), .SEGS(SEGS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_chan_i(req_chan),
    .req_iv_i(req_iv), .req_aad_len_i(req_aad), .req_txt_len_i(req_txt),
    .dat_valid_i(dat_valid), .dat_ready_o(dat_ready), .dat_i(dat),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_tag_o(out_tag), .out_sop_o(out_sop), .out_eop_o(out_eop),
    .out_pattern_o(out_pattern), .out_chan_o(out_chan),
    .out_last_bytes_o(out_lastb), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [BEAT_W-1:0] act, input logic [BEAT_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(int pid, int b);
    return 8'(pid*37 + b*11 + 5);
  endfunction

  function automatic logic [127:0] word_of(int pid, int k);
    logic [127:0] w;
    for (int i = 0; i < 16; i++) w[8*i +: 8] = byte_of(pid, 16*k + i);
    return w;
  endfunction

  // irregular backpressure
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = ((cyc % 5) != 2) && ((cyc % 7) != 3);
    end
  end

  // monitor / scoreboard
  initial begin
    beat_t prev, cur, e;
    bit hold = 0;
    forever begin
      @(negedge clk);
      cur = '{out_data, out_tag, out_sop, out_eop, out_lastb, out_chan};
      if (hold)
        chk(out_valid && cur == prev, "R8", "beat changed under backpressure", BEAT_W'(cur), BEAT_W'(prev));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6", "unexpected beat", BEAT_W'(out_tag), 0);
        end else begin
          e = exp_q.pop_front();
          chk(out_pattern == 3'd2, "R1", "pattern", BEAT_W'(out_pattern), 2);
          chk(out_data == e.data, "R3", "data", out_data, e.data);
          chk(out_tag == e.tag, "R4", "tags", BEAT_W'(out_tag), BEAT_W'(e.tag));
          chk(out_sop == e.sop && out_eop == e.eop, "R6", "sop/eop",
              BEAT_W'({out_sop, out_eop}), BEAT_W'({e.sop, e.eop}));
          chk(out_lastb == e.lastb, "R7", "last bytes", BEAT_W'(out_lastb), BEAT_W'(e.lastb));
          chk(out_chan == e.chan, "R11", "channel", BEAT_W'(out_chan), BEAT_W'(e.chan));
        end
      end
      hold = out_valid && !out_ready;
      prev = cur;
    end
  end

  task automatic send_req(input logic [CHAN_W-1:0] ch, input logic [95:0] iv,
                          input logic [AAD_W-1:0] aad, input logic [TXT_W-1:0] txt);
    @(posedge clk); #1;
    req_valid = 1'b1; req_chan = ch; req_iv = iv; req_aad = aad; req_txt = txt;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // push expected beats (R2 R3 R4 R5 R6 R7 R11), then drive header and body
  task automatic send_pkt(input int pid, input logic [CHAN_W-1:0] ch, input logic [95:0] iv,
                          input int aad, input int txt);
    int total = aad + txt;
    int nw = (total + 15) / 16;
    int nbeats = (nw + 1 + SEGS - 1) / SEGS;
    for (int bi = 0; bi < nbeats; bi++) begin
      beat_t b;
      b = '0;
      for (int s = 0; s < SEGS; s++) begin
        int gs = bi*SEGS + s;
        if (gs == 0) begin
          b.data[127:0] = {32'd2, iv};
          b.tag[1:0] = 2'b01;
        end else if (gs - 1 < nw) begin
          b.data[128*s +: 128] = word_of(pid, gs - 1);
          b.tag[2*s +: 2] = (16*(gs - 1) < aad) ? 2'b10 : 2'b11;
        end
      end
      b.sop = (bi == 0);
      b.eop = (bi == nbeats - 1);
      b.lastb = b.eop ? 5'(((total - 1) % 16) + 1) : 5'd0;
      b.chan = ch;
      exp_q.push_back(b);
    end
    send_req(ch, iv, AAD_W'(aad), TXT_W'(txt));
    for (int k = 0; k < nw; k++) begin
      dat = word_of(pid, k);
      dat_valid = 1'b1;
      do @(negedge clk); while (!dat_ready);
      @(posedge clk); #1;
    end
    dat_valid = 1'b0;
  endtask

  task automatic send_bad(input int aad, input int txt);
    send_req(10'd7, 96'h1, AAD_W'(aad), TXT_W'(txt));
    @(negedge clk);
    chk(err == 1'b1, "R9", "err pulse", BEAT_W'(err), 1);
    @(negedge clk);
    chk(err == 1'b0 && !out_valid && req_ready, "R9", "no beat after refusal",
        BEAT_W'({err, out_valid, req_ready}), BEAT_W'(3'b001));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !dat_ready && !err && req_ready, "R10", "reset state",
        BEAT_W'({out_valid, dat_ready, err, req_ready}), BEAT_W'(4'b0001));
    send_pkt(1, 10'd1,    96'h0123456789abcdef01234567, 16, 16);   // aligned, one beat
    send_pkt(2, 10'd2,    96'hffeeddccbbaa998877665544, 5, 7);     // R5 one shared segment
    send_pkt(3, 10'd3,    96'h000000000000000000000001, 20, 44);   // R5 two beats
    send_bad(0, 9);
    send_pkt(4, 10'd1023, 96'h55aa55aa55aa55aa55aa55aa, 48, 1);    // spills one word
    send_bad(12, 0);
    send_pkt(5, 10'd5,    96'hdeadbeefcafef00d12345678, 100, 300); // seven beats
    send_pkt(6, 10'd6,    96'h111111111111111111111111, 1, 1);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !out_valid, "R6", "all beats delivered",
        BEAT_W'(exp_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule